// File: doc/BRIEF.md
# Exception Delivery Double-Fault Classifier

This block sits in a processor's exception delivery path and decides what happens when a new exception shows up while another one is still being delivered. It keeps a record of the vector currently in delivery and a class for it: segment-related (vectors 10 to 13), page fault (vector 14), double fault (vector 8), or any other vector. When a new exception is raised, the block looks at that class and the class of the new vector. It then dispatches the new vector on its own, turns it into a double fault (vector 8), or, if the double fault itself was being delivered, enters a shutdown state that lasts until reset.

A delivery can be announced from outside with a busy flag and its vector. That covers deliveries started by other logic. Each dispatch the block makes becomes the tracked delivery from then on. A completion strobe ends the tracked delivery. Dispatch results are registered and appear one clock after the new-exception strobe. Stack pushes, descriptor fetch and handler execution are left to the surrounding pipeline.

Top module: `excEscalator`

## Requirements
- R1: After reset, dispValid, doubleFault and shutdown are 0 and dispVec is 0.
- R2: A new exception (newValid high) raised with no delivery in progress gives dispValid=1 on the next cycle, with dispVec equal to the new vector and doubleFault=0. No delivery is in progress when deliverBusy is low and no delivery is tracked.
- R3: While a segment-class vector (10, 11, 12 or 13) is in delivery, a new exception with any vector other than 14 gives dispVec=8 and doubleFault=1 on the next cycle.
- R4: While a segment-class vector is in delivery, a new exception with vector 14 is dispatched as 14, with doubleFault=0.
- R5: While vector 14 is in delivery, a new exception with any vector other than 14 gives dispVec=8 and doubleFault=1 on the next cycle.
- R6: While vector 14 is in delivery, a second vector 14 is dispatched as 14, with doubleFault=0.
- R7: While a vector other than 8 and 10 to 14 is in delivery, a new exception is dispatched with its own vector, with doubleFault=0.
- R8: A new exception raised while vector 8 is in delivery sets shutdown on the next cycle, with no dispatch. Shutdown then stays at 1 until reset, and every later new exception, completion or busy indication is ignored (dispValid stays 0).
- R9: doubleFault is high only in a cycle where dispValid is high and dispVec is 8.
- R10: Each dispatched vector (including 8 on escalation) becomes the delivery in progress, and the next new exception is classified against it.
- R11: deliverDone ends the tracked delivery. A new exception in the same cycle as deliverDone is still classified against the delivery being completed.
- R12: While deliverBusy is high, deliverVec is the delivery in progress and takes priority over the tracked one. Once deliverBusy falls, deliverVec stays tracked as the delivery in progress until completion.
- R13: dispValid is a one-cycle pulse per accepted new exception. dispVec holds its last value between dispatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| deliverBusy | input | 1 | A delivery started outside the block is in progress |
| deliverVec | input | 8 | Vector of that outside delivery |
| newValid | input | 1 | New exception raised this cycle |
| newVec | input | 8 | Vector of the new exception |
| deliverDone | input | 1 | Current delivery has completed |
| dispValid | output | 1 | One-cycle pulse: a vector is dispatched |
| dispVec | output | 8 | Vector to dispatch |
| doubleFault | output | 1 | Pulse marking escalation to vector 8 |
| shutdown | output | 1 | Sticky shutdown after a fault during double-fault delivery |

## Verification
Some properties are checked on every cycle. The double-fault pulse must never appear without a dispatch of vector 8. The control strobes are mutually exclusive, and shutdown never releases. An idle-time exception must pass straight through. A segment-class context must escalate any vector other than 14, and a page-fault pair must never escalate. Other behaviour needs the bench's scenarios. These are the tracking of dispatched vectors across several exceptions in a row, completion arriving in the same cycle as a new exception, an outside busy indication overriding and then loading the tracker, and shutdown ignoring every input afterwards.

// File: rtl/excEscPkg.sv
package excEscPkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_SEG   = 2'd1,
    CLS_PF    = 2'd2,
    CLS_DF    = 2'd3
  } vecCls_e;

  typedef struct packed {
    logic dispOwn;    // dispatch the new vector unchanged
    logic escalate;   // dispatch the double-fault vector instead
    logic enterHalt;  // fault during double-fault delivery
    logic clearTrk;   // completion ends the tracked delivery
    logic loadExt;    // outside delivery becomes tracked
  } ctrlStrb_t;

endpackage

// File: rtl/excVecClass.sv
module excVecClass
  import excEscPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DF_VEC = 8,
  parameter int PF_VEC = 14,
  parameter int SEG_LO = 10,
  parameter int SEG_HI = 13
) (
  input  logic [VEC_W-1:0] vec,
  output vecCls_e          cls
);

  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] PF_V = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] LO_V = VEC_W'(SEG_LO);
  localparam logic [VEC_W-1:0] HI_V = VEC_W'(SEG_HI);

  always_comb begin
    if (vec == DF_V)                      cls = CLS_DF;
    else if (vec == PF_V)                 cls = CLS_PF;
    else if (vec >= LO_V && vec <= HI_V)  cls = CLS_SEG;
    else                                  cls = CLS_OTHER;
  end

endmodule

// File: rtl/excEscCtrl.sv
module excEscCtrl
  import excEscPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      newValid,
  input  logic      deliverBusy,
  input  logic      deliverDone,
  input  logic      ctxActive,
  input  vecCls_e   ctxCls,
  input  vecCls_e   newCls,
  output ctrlStrb_t strb,
  output logic      halted
);

  logic haltedQ;
  logic accept;
  logic anyDisp;

  assign accept = newValid && !haltedQ;

  always_comb begin
    strb = '0;
    if (accept) begin
      if (!ctxActive) begin
        strb.dispOwn = 1'b1;
      end else begin
        case (ctxCls)
          CLS_DF:  strb.enterHalt = 1'b1;
          CLS_SEG,
          CLS_PF: begin
            if (newCls == CLS_PF) strb.dispOwn  = 1'b1;
            else                  strb.escalate = 1'b1;
          end
          default: strb.dispOwn = 1'b1;
        endcase
      end
    end
    anyDisp       = strb.dispOwn || strb.escalate;
    strb.clearTrk = !haltedQ && deliverDone && !anyDisp;
    strb.loadExt  = !haltedQ && deliverBusy && !deliverDone && !anyDisp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) haltedQ <= 1'b0;
    else if (strb.enterHalt) haltedQ <= 1'b1;
  end

  assign halted = haltedQ;

  // R8: once halted, only reset releases the block
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    haltedQ |=> haltedQ);

  // R9: at most one outcome per new exception
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dispOwn, strb.escalate, strb.enterHalt}));

  // R8: nothing is accepted while halted
  a_r8_no_accept_halted: assert property (@(posedge clk) disable iff (!rstN)
    haltedQ |-> !(strb.dispOwn || strb.escalate || strb.loadExt || strb.clearTrk));

endmodule

// File: rtl/excEscDatapath.sv
module excEscDatapath
  import excEscPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DF_VEC = 8,
  parameter int PF_VEC = 14,
  parameter int SEG_LO = 10,
  parameter int SEG_HI = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             deliverBusy,
  input  logic [VEC_W-1:0] deliverVec,
  input  logic             newValid,
  input  logic [VEC_W-1:0] newVec,
  input  logic             halted,
  input  ctrlStrb_t        strb,
  output logic             ctxActive,
  output vecCls_e          ctxCls,
  output vecCls_e          newCls,
  output logic             dispValid,
  output logic [VEC_W-1:0] dispVec,
  output logic             doubleFault
);

  localparam int NUM_CLS = 2;
  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);
  localparam logic [VEC_W-1:0] PF_V = VEC_W'(PF_VEC);

  logic             trkActive;
  logic [VEC_W-1:0] trkVec;
  logic [VEC_W-1:0] ctxVec;
  logic [VEC_W-1:0] selVec;
  logic             dispValidQ;
  logic [VEC_W-1:0] dispVecQ;
  logic             dfQ;

  logic [VEC_W-1:0] clsIn  [NUM_CLS];
  vecCls_e          clsOut [NUM_CLS];

  // outside indication overrides the tracked delivery
  assign ctxVec    = deliverBusy ? deliverVec : trkVec;
  assign ctxActive = deliverBusy || trkActive;

  assign clsIn[0] = ctxVec;
  assign clsIn[1] = newVec;

  for (genvar gi = 0; gi < NUM_CLS; gi++) begin : g_cls
    excVecClass #(
      .VEC_W (VEC_W),
      .DF_VEC(DF_VEC),
      .PF_VEC(PF_VEC),
      .SEG_LO(SEG_LO),
      .SEG_HI(SEG_HI)
    ) i_cls (
      .vec(clsIn[gi]),
      .cls(clsOut[gi])
    );
  end

  assign ctxCls = clsOut[0];
  assign newCls = clsOut[1];

  assign selVec = strb.escalate ? DF_V : newVec;

  // delivery tracker: a dispatch wins over completion and outside load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trkActive <= 1'b0;
      trkVec    <= '0;
    end else if (strb.dispOwn || strb.escalate) begin
      trkActive <= 1'b1;
      trkVec    <= selVec;
    end else if (strb.clearTrk) begin
      trkActive <= 1'b0;
    end else if (strb.loadExt) begin
      trkActive <= 1'b1;
      trkVec    <= deliverVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispValidQ <= 1'b0;
      dispVecQ   <= '0;
      dfQ        <= 1'b0;
    end else begin
      dispValidQ <= strb.dispOwn || strb.escalate;
      dfQ        <= strb.escalate;
      if (strb.dispOwn || strb.escalate) dispVecQ <= selVec;
    end
  end

  assign dispValid   = dispValidQ;
  assign dispVec     = dispVecQ;
  assign doubleFault = dfQ;

  // R9: escalation flag only with a dispatch of the double-fault vector
  a_r9_df_with_vec8: assert property (@(posedge clk) disable iff (!rstN)
    doubleFault |-> (dispValid && dispVec == DF_V));

  // R2: idle-time exception passes through unchanged
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    (newValid && !halted && !ctxActive) |=>
      (dispValid && !doubleFault && dispVec == $past(newVec)));

  // R3: segment context escalates anything but a page fault
  a_r3_seg_escalate: assert property (@(posedge clk) disable iff (!rstN)
    (newValid && !halted && ctxActive && ctxCls == CLS_SEG && newVec != PF_V) |=>
      (doubleFault && dispVec == DF_V));

  // R6: page fault during page-fault delivery never escalates
  a_r6_pf_pair: assert property (@(posedge clk) disable iff (!rstN)
    (newValid && !halted && ctxActive && ctxCls == CLS_PF && newVec == PF_V) |=>
      (dispValid && !doubleFault && dispVec == PF_V));

  // R8: no dispatch once halted
  a_r8_no_disp_halted: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !dispValid);

endmodule

// File: rtl/excEscalator.sv
module excEscalator
  import excEscPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DF_VEC = 8,
  parameter int PF_VEC = 14,
  parameter int SEG_LO = 10,
  parameter int SEG_HI = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             deliverBusy,
  input  logic [VEC_W-1:0] deliverVec,
  input  logic             newValid,
  input  logic [VEC_W-1:0] newVec,
  input  logic             deliverDone,
  output logic             dispValid,
  output logic [VEC_W-1:0] dispVec,
  output logic             doubleFault,
  output logic             shutdown
);

  ctrlStrb_t strb;
  logic      halted;
  logic      ctxActive;
  vecCls_e   ctxCls;
  vecCls_e   newCls;

  excEscCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .newValid   (newValid),
    .deliverBusy(deliverBusy),
    .deliverDone(deliverDone),
    .ctxActive  (ctxActive),
    .ctxCls     (ctxCls),
    .newCls     (newCls),
    .strb       (strb),
    .halted     (halted)
  );

  excEscDatapath #(
    .VEC_W (VEC_W),
    .DF_VEC(DF_VEC),
    .PF_VEC(PF_VEC),
    .SEG_LO(SEG_LO),
    .SEG_HI(SEG_HI)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .deliverBusy(deliverBusy),
    .deliverVec (deliverVec),
    .newValid   (newValid),
    .newVec     (newVec),
    .halted     (halted),
    .strb       (strb),
    .ctxActive  (ctxActive),
    .ctxCls     (ctxCls),
    .newCls     (newCls),
    .dispValid  (dispValid),
    .dispVec    (dispVec),
    .doubleFault(doubleFault)
  );

  assign shutdown = halted;

endmodule

// File: tb/test_excEscalator.sv
module test_excEscalator;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NTBL       = 13;

  // {busy, ctxVec, newVec, expVec, expDf}
  localparam logic [25:0] TBL [NTBL] = '{
    {1'b0, 8'd0,   8'd3,   8'd3,   1'b0},
    {1'b1, 8'd10,  8'd0,   8'd8,   1'b1},
    {1'b1, 8'd13,  8'd11,  8'd8,   1'b1},
    {1'b1, 8'd12,  8'd14,  8'd14,  1'b0},
    {1'b1, 8'd11,  8'd14,  8'd14,  1'b0},
    {1'b1, 8'd14,  8'd13,  8'd8,   1'b1},
    {1'b1, 8'd14,  8'd6,   8'd8,   1'b1},
    {1'b1, 8'd14,  8'd14,  8'd14,  1'b0},
    {1'b1, 8'd3,   8'd13,  8'd13,  1'b0},
    {1'b1, 8'd32,  8'd14,  8'd14,  1'b0},
    {1'b1, 8'd15,  8'd10,  8'd10,  1'b0},
    {1'b0, 8'd0,   8'd14,  8'd14,  1'b0},
    {1'b0, 8'd0,   8'd255, 8'd255, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       deliverBusy = 1'b0;
  logic [7:0] deliverVec = '0;
  logic       newValid = 1'b0;
  logic [7:0] newVec = '0;
  logic       deliverDone = 1'b0;
  logic       dispValid;
  logic [7:0] dispVec;
  logic       doubleFault;
  logic       shutdown;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excEscalator i_excEscalator (
    .clk        (clk),
    .rstN       (rstN),
    .deliverBusy(deliverBusy),
    .deliverVec (deliverVec),
    .newValid   (newValid),
    .newVec     (newVec),
    .deliverDone(deliverDone),
    .dispValid  (dispValid),
    .dispVec    (dispVec),
    .doubleFault(doubleFault),
    .shutdown   (shutdown)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // check all four outputs at once
  task automatic chkOut(input string tag, input bit v, input int vec,
                        input bit df, input bit sd);
    chk(dispValid == v, tag, "dispValid", int'(dispValid), int'(v));
    chk(int'(dispVec) == vec, tag, "dispVec", int'(dispVec), vec);
    chk(doubleFault == df, tag, "doubleFault", int'(doubleFault), int'(df));
    chk(shutdown == sd, tag, "shutdown", int'(shutdown), int'(sd));
  endtask

  // drive one cycle at a negedge; outputs are sampled at the next negedge
  task automatic drive(input bit busy, input int bvec, input bit nv,
                       input int nvec, input bit done);
    @(negedge clk);
    deliverBusy = busy;
    deliverVec  = 8'(bvec);
    newValid    = nv;
    newVec      = 8'(nvec);
    deliverDone = done;
    @(negedge clk);
    deliverBusy = 1'b0;
    newValid    = 1'b0;
    deliverDone = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic string tagOf(input logic [25:0] e);
    logic       b;
    logic [7:0] c;
    logic [7:0] n;
    b = e[25];
    c = e[24:17];
    n = e[16:9];
    if (!b) return "R2";
    if (c >= 8'd10 && c <= 8'd13) return (n == 8'd14) ? "R4" : "R3";
    if (c == 8'd14) return (n == 8'd14) ? "R6" : "R5";
    return "R7";
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset values
    chkOut("R1", 1'b0, 0, 1'b0, 1'b0);

    // table: each entry from an idle tracker
    for (int i = 0; i < NTBL; i++) begin
      drive(TBL[i][25], int'(TBL[i][24:17]), 1'b1, int'(TBL[i][16:9]), 1'b0);
      chkOut(tagOf(TBL[i]), 1'b1, int'(TBL[i][8:1]), TBL[i][0], 1'b0);
      drive(1'b0, 0, 1'b0, 0, 1'b1);  // complete the dispatched delivery
      // R13: pulse ends, vector held
      chkOut("R13", 1'b0, int'(TBL[i][8:1]), 1'b0, 1'b0);
    end

    // R10: chain of tracked deliveries ending in shutdown
    drive(1'b0, 0, 1'b1, 13, 1'b0);
    chkOut("R10", 1'b1, 13, 1'b0, 1'b0);
    drive(1'b0, 0, 1'b1, 11, 1'b0);
    chkOut("R10", 1'b1, 8, 1'b1, 1'b0);
    // R9: flag does not linger
    drive(1'b0, 0, 1'b0, 0, 1'b0);
    chkOut("R9", 1'b0, 8, 1'b0, 1'b0);
    drive(1'b0, 0, 1'b1, 5, 1'b0);
    chkOut("R8", 1'b0, 8, 1'b0, 1'b1);
    drive(1'b0, 0, 1'b1, 3, 1'b0);
    chkOut("R8", 1'b0, 8, 1'b0, 1'b1);
    drive(1'b1, 3, 1'b1, 3, 1'b1);
    chkOut("R8", 1'b0, 8, 1'b0, 1'b1);
    doReset();
    chkOut("R1", 1'b0, 0, 1'b0, 1'b0);

    // R8: outside delivery of vector 8
    drive(1'b1, 8, 1'b1, 14, 1'b0);
    chkOut("R8", 1'b0, 0, 1'b0, 1'b1);
    doReset();

    // R11: completion clears the tracker
    drive(1'b0, 0, 1'b1, 12, 1'b0);
    chkOut("R11", 1'b1, 12, 1'b0, 1'b0);
    drive(1'b0, 0, 1'b0, 0, 1'b1);
    drive(1'b0, 0, 1'b1, 11, 1'b0);
    chkOut("R11", 1'b1, 11, 1'b0, 1'b0);
    // R11: same-cycle completion still classifies against vector 11
    drive(1'b0, 0, 1'b1, 3, 1'b1);
    chkOut("R11", 1'b1, 8, 1'b1, 1'b0);
    drive(1'b0, 0, 1'b0, 0, 1'b1);
    drive(1'b0, 0, 1'b1, 4, 1'b0);
    chkOut("R11", 1'b1, 4, 1'b0, 1'b0);
    drive(1'b0, 0, 1'b0, 0, 1'b1);

    // R12: outside delivery loads the tracker
    drive(1'b1, 14, 1'b0, 0, 1'b0);
    chkOut("R12", 1'b0, 4, 1'b0, 1'b0);
    drive(1'b0, 0, 1'b1, 2, 1'b0);
    chkOut("R12", 1'b1, 8, 1'b1, 1'b0);
    drive(1'b0, 0, 1'b0, 0, 1'b1);
    // R12: busy overrides a tracked ordinary vector
    drive(1'b0, 0, 1'b1, 3, 1'b0);
    chkOut("R12", 1'b1, 3, 1'b0, 1'b0);
    drive(1'b1, 10, 1'b1, 5, 1'b0);
    chkOut("R12", 1'b1, 8, 1'b1, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule